// File: doc/BRIEF.md
# RISC Integer Decode-Execute Unit

This unit takes one 32-bit instruction word at a time from a small load/store RISC subset and carries it out. It holds a 32 x 32-bit register file, a field decoder for the register-register and register-immediate formats, and an ALU. The ALU does add, subtract, AND, OR, signed set-less-than and load-upper-immediate. Word loads and stores use a synchronous data-memory port. Their address is a base register plus a sign-extended offset.

A two-state controller sequences the unit. In `ST_EXEC` the unit accepts an instruction whenever `instr_valid_i` is high, since `instr_ready_o` is high in that state. ALU results and stores complete at that same clock edge. A load drives the read strobe, and the transition *load issue* moves the controller to `ST_LOAD_WAIT`. Memory returns the word one cycle later. In `ST_LOAD_WAIT` the word is written to the target register and `instr_ready_o` is low. The unconditional transition *load retire* then returns the controller to `ST_EXEC`. Fetch, program-counter logic, sub-word accesses and exceptions belong to the surrounding core.

Top module: `rdx_core`

## Requirements
- R1: Bits 31:26 of the instruction are the opcode and bits 25:21 are the first source register. Bits 20:16 are the second source register, or the target register in the immediate format. In the register format, bits 15:11 name the destination and bits 5:0 select the operation. For example, word 32'h02324820 writes r17 + r18 into r9.
- R2: Opcode 0 with function code 32 adds, 34 subtracts (first source minus second), 36 ANDs and 37 ORs. Results wrap modulo 2^32.
- R3: Function code 42 (opcode 0) and opcode 10 write 1 to the destination when the first operand is less than the second, and 0 otherwise. Both operands are compared as signed two's-complement values. For opcode 10 the second operand is the immediate.
- R4: Opcode 15 writes the 16-bit constant into bits 31:16 of the target and clears bits 15:0. Opcode 13 ORs a constant into the low half, so a lui followed by an ori builds any 32-bit value.
- R5: The immediates of add-immediate (opcode 8), set-less-than-immediate and the load/store offsets are sign-extended. AND-immediate (opcode 12) and OR-immediate (opcode 13) zero-extend theirs.
- R6: Register 0 always reads as zero, and writes to it are discarded.
- R7: Load word (opcode 35) drives `mem_rd_en_o` with address rs + offset for one cycle. The returned word is written to rt at the next edge, and `instr_ready_o` is low during that cycle. An instruction issued right after the load sees the loaded value.
- R8: Store word (opcode 43) drives `mem_wr_en_o`, the address rs + offset and the data from rt in the cycle it is accepted. It writes no register.
- R9: Any other opcode, or opcode 0 with any other function code, writes no register and no memory. It also raises `illegal_o` for exactly the one cycle after it is accepted.
- R10: During and after reset the controller is in `ST_EXEC`, `instr_ready_o` is high, and `illegal_o`, `mem_rd_en_o` and `mem_wr_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | Instruction word present |
| instr_i | input | 32 | Instruction word |
| instr_ready_o | output | 1 | Unit can accept an instruction this cycle |
| mem_addr_o | output | 32 | Byte address for load or store |
| mem_rd_en_o | output | 1 | Load request, data expected next cycle |
| mem_wr_en_o | output | 1 | Store request, written at this edge |
| mem_wr_data_o | output | 32 | Store data |
| mem_rd_data_i | input | 32 | Load data, valid the cycle after the request |
| illegal_o | output | 1 | One-cycle pulse after an unsupported instruction |

## Verification
The bench targets operands that differ in sign. An unsigned set-less-than would report 0x80000000 < 5 as false, and a subtract with broken wrap would give the wrong answer for 0x80000000 - 5. The bench also checks extension: a decoder that sign-extends OR-immediate turns 0x8000 into 0xFFFF8000, and one that zero-extends offsets misses the word stored at base 0x104 with offset -4. It issues an instruction that uses a loaded register immediately after the load, which catches a stall that is missing or a cycle too long. It also writes to register 0 and issues unsupported words aimed at a live register, so a design that leaks writes or holds the illegal flag shows a wrong value.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_ADDI  = 6'd8;
    localparam logic [5:0] OP_SLTI  = 6'd10;
    localparam logic [5:0] OP_ANDI  = 6'd12;
    localparam logic [5:0] OP_ORI   = 6'd13;
    localparam logic [5:0] OP_LUI   = 6'd15;
    localparam logic [5:0] OP_LW    = 6'd35;
    localparam logic [5:0] OP_SW    = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT,
        ALU_LUI
    } alu_op_e;

    typedef enum logic {
        ST_EXEC,
        ST_LOAD_WAIT
    } state_e;

    // Decoded control record for one instruction word
    typedef struct packed {
        alu_op_e alu_op;
        logic    use_imm;   // second ALU operand is the extended immediate
        logic    dst_rd;    // destination taken from rd instead of rt
        logic    reg_wr;    // ALU result goes to the register file
        logic    mem_rd;
        logic    mem_wr;
        logic    illegal;
    } dec_t;

endpackage

// File: rtl/rdx_decode.sv
module rdx_decode
    import rdx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr_i,
    output dec_t            dec_o,
    output logic [XLEN-1:0] imm_o
);

    localparam int IMMW = 16;

    logic [5:0]      opcode;
    logic [5:0]      funct;
    logic [IMMW-1:0] imm16;
    logic            zext;
    logic            unused_fields;

    assign opcode        = instr_i[31:26];
    assign funct         = instr_i[5:0];
    assign imm16         = instr_i[15:0];
    assign unused_fields = ^instr_i[25:6];

    always_comb begin
        dec_o        = '0;
        dec_o.alu_op = ALU_ADD;
        zext         = 1'b0;
        unique case (opcode)
            OP_RTYPE: begin
                dec_o.reg_wr = 1'b1;
                dec_o.dst_rd = 1'b1;
                unique case (funct)
                    FN_ADD: dec_o.alu_op = ALU_ADD;
                    FN_SUB: dec_o.alu_op = ALU_SUB;
                    FN_AND: dec_o.alu_op = ALU_AND;
                    FN_OR:  dec_o.alu_op = ALU_OR;
                    FN_SLT: dec_o.alu_op = ALU_SLT;
                    default: begin
                        dec_o.reg_wr  = 1'b0;
                        dec_o.illegal = 1'b1;
                    end
                endcase
            end
            OP_ADDI: begin
                dec_o.reg_wr  = 1'b1;
                dec_o.use_imm = 1'b1;
            end
            OP_SLTI: begin
                dec_o.reg_wr  = 1'b1;
                dec_o.use_imm = 1'b1;
                dec_o.alu_op  = ALU_SLT;
            end
            OP_ANDI: begin
                dec_o.reg_wr  = 1'b1;
                dec_o.use_imm = 1'b1;
                dec_o.alu_op  = ALU_AND;
                zext          = 1'b1;
            end
            OP_ORI: begin
                dec_o.reg_wr  = 1'b1;
                dec_o.use_imm = 1'b1;
                dec_o.alu_op  = ALU_OR;
                zext          = 1'b1;
            end
            OP_LUI: begin
                dec_o.reg_wr  = 1'b1;
                dec_o.use_imm = 1'b1;
                dec_o.alu_op  = ALU_LUI;
                zext          = 1'b1;
            end
            OP_LW: begin
                dec_o.use_imm = 1'b1;
                dec_o.mem_rd  = 1'b1;
            end
            OP_SW: begin
                dec_o.use_imm = 1'b1;
                dec_o.mem_wr  = 1'b1;
            end
            default: dec_o.illegal = 1'b1;
        endcase
    end

    assign imm_o = zext ? {{(XLEN-IMMW){1'b0}}, imm16}
                        : {{(XLEN-IMMW){imm16[IMMW-1]}}, imm16};

endmodule

// File: rtl/rdx_alu.sv
module rdx_alu
    import rdx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] res_o
);

    localparam int HALF = 16;

    logic lt;

    assign lt = $signed(a_i) < $signed(b_i);

    always_comb begin
        unique case (op_i)
            ALU_ADD: res_o = a_i + b_i;
            ALU_SUB: res_o = a_i - b_i;
            ALU_AND: res_o = a_i & b_i;
            ALU_OR:  res_o = a_i | b_i;
            ALU_SLT: res_o = {{(XLEN-1){1'b0}}, lt};
            ALU_LUI: res_o = {b_i[HALF-1:0], {(XLEN-HALF){1'b0}}};
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/rdx_regfile.sv
module rdx_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra_addr_i,
    output logic [XLEN-1:0] ra_data_o,
    input  logic [AW-1:0]   rb_addr_i,
    output logic [XLEN-1:0] rb_data_o,
    input  logic            we_i,
    input  logic [AW-1:0]   waddr_i,
    input  logic [XLEN-1:0] wdata_i
);

    logic [XLEN-1:0] regs [NREG];

    assign regs[0] = '0;

    for (genvar g = 1; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we_i && (waddr_i == AW'(g))) begin
                regs[g] <= wdata_i;
            end
        end
    end

    assign ra_data_o = regs[ra_addr_i];
    assign rb_data_o = regs[rb_addr_i];

    // R6
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_addr_i == '0) |-> (ra_data_o == '0));

    // R6
    zero_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && waddr_i == '0 && rb_addr_i == '0) |=> (regs[0] == '0));

endmodule

// File: rtl/rdx_core.sv
module rdx_core
    import rdx_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid_i,
    input  logic [31:0]     instr_i,
    output logic            instr_ready_o,
    output logic [XLEN-1:0] mem_addr_o,
    output logic            mem_rd_en_o,
    output logic            mem_wr_en_o,
    output logic [XLEN-1:0] mem_wr_data_o,
    input  logic [XLEN-1:0] mem_rd_data_i,
    output logic            illegal_o
);

    localparam int AW = $clog2(NREG);

    state_e          state_q, state_d;
    logic [AW-1:0]   ld_reg_q;
    logic            illegal_q;

    dec_t            dec;
    logic [XLEN-1:0] imm;
    logic [AW-1:0]   rs, rt, rd;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_res;
    logic            accept;
    logic            rf_we;
    logic [AW-1:0]   rf_waddr;
    logic [XLEN-1:0] rf_wdata;

    assign rs = AW'(instr_i[25:21]);
    assign rt = AW'(instr_i[20:16]);
    assign rd = AW'(instr_i[15:11]);

    rdx_decode #(.XLEN(XLEN)) dec_i (
        .instr_i (instr_i),
        .dec_o   (dec),
        .imm_o   (imm)
    );

    rdx_regfile #(.XLEN(XLEN), .NREG(NREG)) rf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ra_addr_i (rs),
        .ra_data_o (rs_val),
        .rb_addr_i (rt),
        .rb_data_o (rt_val),
        .we_i      (rf_we),
        .waddr_i   (rf_waddr),
        .wdata_i   (rf_wdata)
    );

    assign alu_b = dec.use_imm ? imm : rt_val;

    rdx_alu #(.XLEN(XLEN)) alu_i (
        .op_i  (dec.alu_op),
        .a_i   (rs_val),
        .b_i   (alu_b),
        .res_o (alu_res)
    );

    assign accept = instr_valid_i && instr_ready_o;

    // State register and registered flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_EXEC;
            ld_reg_q  <= '0;
            illegal_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            illegal_q <= accept && dec.illegal;
            if (accept && dec.mem_rd) begin
                ld_reg_q <= rt;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EXEC:      if (accept && dec.mem_rd) state_d = ST_LOAD_WAIT;
            ST_LOAD_WAIT: state_d = ST_EXEC;
            default:      state_d = ST_EXEC;
        endcase
    end

    // Output and datapath control
    always_comb begin
        instr_ready_o = 1'b0;
        rf_we         = 1'b0;
        rf_waddr      = dec.dst_rd ? rd : rt;
        rf_wdata      = alu_res;
        mem_rd_en_o   = 1'b0;
        mem_wr_en_o   = 1'b0;
        unique case (state_q)
            ST_EXEC: begin
                instr_ready_o = 1'b1;
                rf_we         = accept && dec.reg_wr;
                mem_rd_en_o   = accept && dec.mem_rd;
                mem_wr_en_o   = accept && dec.mem_wr;
            end
            ST_LOAD_WAIT: begin
                rf_we    = 1'b1;
                rf_waddr = ld_reg_q;
                rf_wdata = mem_rd_data_i;
            end
            default: ;
        endcase
    end

    assign mem_addr_o    = alu_res;
    assign mem_wr_data_o = rt_val;
    assign illegal_o     = illegal_q;

    // R10
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_EXEC && !illegal_o));

    // R7
    load_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD_WAIT) |=> (state_q == ST_EXEC));

    // R7
    load_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> !instr_ready_o);

    // R8
    store_no_regwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en_o |-> (!rf_we && !mem_rd_en_o));

    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.illegal) |-> (!rf_we && !mem_wr_en_o && !mem_rd_en_o));

    // R9
    illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.illegal) |=> illegal_o);

    // R3
    slt_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.alu_op == ALU_SLT && !dec.mem_rd && !dec.mem_wr)
            |-> (alu_res[XLEN-1:1] == '0));

    // R4
    lui_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.alu_op == ALU_LUI) |-> (rf_wdata[15:0] == '0));

endmodule

// File: tb/rdx_core_tb.sv
`timescale 1ns/1ps
module rdx_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [31:0] instr = '0;
    logic        ready;
    logic [31:0] maddr, mwdata;
    logic [31:0] mrdata = '0;
    logic        mre, mwe, illegal;

    int checks = 0;
    int fails  = 0;
    int writes = 0;

    logic [31:0] mem [256];

    always #10 clk = ~clk;

    rdx_core dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid_i (valid),
        .instr_i       (instr),
        .instr_ready_o (ready),
        .mem_addr_o    (maddr),
        .mem_rd_en_o   (mre),
        .mem_wr_en_o   (mwe),
        .mem_wr_data_o (mwdata),
        .mem_rd_data_i (mrdata),
        .illegal_o     (illegal)
    );

    always @(posedge clk) begin
        if (mwe) begin
            mem[maddr[9:2]] <= mwdata;
            writes <= writes + 1;
        end
        if (mre) mrdata <= mem[maddr[9:2]];
    end

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] s,
                                          input logic [4:0] t, input logic [4:0] d);
        return {6'd0, s, t, d, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] o, input logic [4:0] s,
                                          input logic [4:0] t, input logic [15:0] k);
        return {o, s, t, k};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [4:0]  dst;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{enc_i(6'd8,  5'd0,  5'd1,  16'd5),      5'd1,  32'd5,         4'd5},  // R5
        '{enc_i(6'd8,  5'd0,  5'd2,  16'hFFFD),   5'd2,  32'hFFFFFFFD,  4'd5},  // R5
        '{enc_r(6'd32, 5'd1,  5'd2,  5'd3),       5'd3,  32'd2,         4'd2},  // R2
        '{enc_r(6'd34, 5'd2,  5'd1,  5'd4),       5'd4,  32'hFFFFFFF8,  4'd2},  // R2
        '{enc_i(6'd15, 5'd0,  5'd5,  16'hAAAA),   5'd5,  32'hAAAA0000,  4'd4},  // R4
        '{enc_i(6'd13, 5'd5,  5'd5,  16'h5555),   5'd5,  32'hAAAA5555,  4'd4},  // R4
        '{enc_i(6'd12, 5'd5,  5'd6,  16'hFF0F),   5'd6,  32'h00005505,  4'd5},  // R5
        '{enc_r(6'd36, 5'd5,  5'd2,  5'd7),       5'd7,  32'hAAAA5555,  4'd2},  // R2
        '{enc_r(6'd37, 5'd1,  5'd4,  5'd8),       5'd8,  32'hFFFFFFFD,  4'd2},  // R2
        '{enc_r(6'd42, 5'd2,  5'd1,  5'd9),       5'd9,  32'd1,         4'd3},  // R3
        '{enc_r(6'd42, 5'd1,  5'd2,  5'd10),      5'd10, 32'd0,         4'd3},  // R3
        '{enc_i(6'd10, 5'd2,  5'd11, 16'hFFFE),   5'd11, 32'd1,         4'd3},  // R3
        '{enc_i(6'd10, 5'd1,  5'd12, 16'd5),      5'd12, 32'd0,         4'd3},  // R3
        '{enc_i(6'd8,  5'd5,  5'd13, 16'hFFFF),   5'd13, 32'hAAAA5554,  4'd5},  // R5
        '{enc_r(6'd32, 5'd1,  5'd1,  5'd0),       5'd0,  32'd0,         4'd6},  // R6
        '{enc_i(6'd13, 5'd0,  5'd14, 16'h8000),   5'd14, 32'h00008000,  4'd5},  // R5
        '{enc_i(6'd8,  5'd0,  5'd17, 16'd100),    5'd17, 32'd100,       4'd5},  // R5
        '{enc_i(6'd8,  5'd0,  5'd18, 16'd23),     5'd18, 32'd23,        4'd5},  // R5
        '{32'h02324820,                           5'd9,  32'd123,       4'd1},  // R1
        '{enc_i(6'd15, 5'd0,  5'd19, 16'h8000),   5'd19, 32'h80000000,  4'd4},  // R4
        '{enc_r(6'd34, 5'd19, 5'd1,  5'd20),      5'd20, 32'h7FFFFFFB,  4'd2},  // R2
        '{enc_r(6'd42, 5'd19, 5'd1,  5'd21),      5'd21, 32'd1,         4'd3}   // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        while (!ready) @(negedge clk);
        instr = w;
        valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        instr = '0;
    endtask

    // Store a register to scratch word 252 (byte 0x3F0) and return it
    task automatic peek(input logic [4:0] r, output logic [31:0] v);
        issue(enc_i(6'd43, 5'd0, r, 16'h03F0));
        v = mem[252];
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int w0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 outputs while reset is held
        check("R10", {28'd0, ready, illegal, mre, mwe}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", {28'd0, ready, illegal, mre, mwe}, 32'h8);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].ins);
            peek(VECS[i].dst, v);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].exp);
        end

        // R8 store with a negative offset from base 0x104
        issue(enc_i(6'd15, 5'd0, 5'd22, 16'hDEAD));
        issue(enc_i(6'd13, 5'd22, 5'd22, 16'hBEEF));
        issue(enc_i(6'd8, 5'd0, 5'd23, 16'h0104));
        w0 = writes;
        issue(enc_i(6'd43, 5'd23, 5'd22, 16'hFFFC));
        check("R8 store data", mem[64], 32'hDEADBEEF);
        check("R8 one write", 32'(writes - w0), 32'd1);

        // R7 load then immediate use
        issue(enc_i(6'd35, 5'd23, 5'd15, 16'hFFFC));
        check("R7 stall", {31'd0, ready}, 32'd0);
        issue(enc_r(6'd32, 5'd15, 5'd1, 5'd16));
        peek(5'd16, v);
        check("R7 load use", v, 32'hDEADBEF4);
        peek(5'd15, v);
        check("R7 loaded", v, 32'hDEADBEEF);

        // R9 unsupported opcode and function aimed at a live register
        issue(enc_i(6'd8, 5'd0, 5'd24, 16'd7));
        w0 = writes;
        issue(enc_i(6'd63, 5'd0, 5'd24, 16'd0));
        check("R9 flag op", {31'd0, illegal}, 32'd1);
        @(negedge clk);
        check("R9 flag drop", {31'd0, illegal}, 32'd0);
        issue(enc_r(6'd63, 5'd1, 5'd1, 5'd24));
        check("R9 flag funct", {31'd0, illegal}, 32'd1);
        issue(enc_i(6'd44, 5'd0, 5'd24, 16'h03F0));
        check("R9 no mem write", 32'(writes - w0), 32'd0);
        peek(5'd24, v);
        check("R9 reg kept", v, 32'd7);
        check("R9 flag clear", {31'd0, illegal}, 32'd0);

        // R6 write to r0 through the immediate path
        issue(enc_i(6'd8, 5'd0, 5'd0, 16'd99));
        peek(5'd0, v);
        check("R6 r0 addi", v, 32'd0);

        finish_run();
    end

endmodule